// File: doc/BRIEF.md
# Register-Table Paged Address Translator

This block maps a logical address onto a physical address through a small page table kept entirely in flip-flops. The low bits of the logical address are the offset within a page, and they pass through untouched. The remaining high bits are the page number, which indexes the table to obtain a frame number. The physical address is that frame number placed directly above the offset, so no adder is needed.

A length register limits which page numbers are legal. The requested page must be strictly below the stored length, and its table entry must be marked valid. When either test fails, the block flags a fault instead of returning an address. Only a write port qualified by a privilege input can change the table entries or the length.

A translation request is accepted on any cycle. Its result appears on the next cycle as a one-cycle pulse.

Top module: `page_xlate_top`

## Requirements
- R1: On a successful translation, bits [OFS_W-1:0] of `rsp_paddr` equal bits [OFS_W-1:0] of the requesting `req_laddr`.
- R2: On a successful translation, bits [FRM_W+OFS_W-1:OFS_W] of `rsp_paddr` equal the frame stored for page `req_laddr[PG_W+OFS_W-1:OFS_W]`. For example, with page 1→frame 6 and page 2→frame 4, logical 5'b01_000 gives 7'b0110_000 and logical 5'b10_111 gives 7'b0100_111.
- R3: A page number greater than or equal to the stored length gives `rsp_fault`=1. This includes the boundary case page == length.
- R4: A page number that is within the length but whose entry is not valid gives `rsp_fault`=1.
- R5: A write with `cfg_we`=1 and `cfg_priv`=0 changes neither the table nor the length.
- R6: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid`=1. While `rsp_valid` is low, `rsp_paddr` and `rsp_fault` are 0.
- R7: After reset, `rsp_valid` is 0, the length is 0 and every entry is invalid, so every request faults.
- R8: A privileged write takes effect at the clock edge where it is presented. A request in that same cycle uses the old contents, and a request in the next cycle uses the new ones. `cfg_sel_len`=1 writes the length from `cfg_len`. `cfg_sel_len`=0 writes entry `cfg_idx` with `cfg_frame` and `cfg_entry_ok`.
- R9: A faulting result drives `rsp_paddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Table or length write strobe |
| cfg_priv | input | 1 | Privilege qualifier; a write is ignored without it |
| cfg_sel_len | input | 1 | 1: write the length register, 0: write a table entry |
| cfg_idx | input | PG_W | Entry index to write |
| cfg_frame | input | FRM_W | Frame number to store |
| cfg_entry_ok | input | 1 | Valid bit to store |
| cfg_len | input | PG_W+1 | New length value |
| req_valid | input | 1 | Translate request |
| req_laddr | input | PG_W+OFS_W | Logical address |
| rsp_valid | output | 1 | Result pulse, one cycle after the request |
| rsp_paddr | output | FRM_W+OFS_W | Physical address |
| rsp_fault | output | 1 | Bound or invalid-entry fault |

## Verification
A wrong stored frame shows as a wrong upper field of `rsp_paddr` on the first request to that page, one cycle after that request. A wrong length or valid bit shows as a fault that appears or disappears on the next request near the boundary. A write that slips past the privilege gate becomes visible on the following request to the affected page. Because the bench model is compared every cycle, a broken pulse or a non-zero idle output is caught in the cycle it occurs.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
    // Default geometry: 8-word pages, 16 frames, up to 4 pages.
    localparam int DEF_OFS_W = 3;
    localparam int DEF_PG_W  = 2;
    localparam int DEF_FRM_W = 4;

    typedef enum logic [1:0] {
        XL_OK      = 2'd0,
        XL_BOUND   = 2'd1,
        XL_INVALID = 2'd2
    } xl_cause_e;

    function automatic logic cause_is_fault(xl_cause_e c);
        return c != XL_OK;
    endfunction
endpackage

// File: rtl/pt_regfile.sv
module pt_regfile #(
    parameter int PG_W  = pgx_pkg::DEF_PG_W,
    parameter int FRM_W = pgx_pkg::DEF_FRM_W,
    localparam int NPG   = 1 << PG_W,
    localparam int LEN_W = PG_W + 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic                       priv,
    input  logic                       sel_len,
    input  logic [PG_W-1:0]            idx,
    input  logic [FRM_W-1:0]           frame_in,
    input  logic                       ok_in,
    input  logic [LEN_W-1:0]           len_in,
    output logic [NPG-1:0][FRM_W-1:0]  frame_q,
    output logic [NPG-1:0]             ok_q,
    output logic [LEN_W-1:0]           len_q
);
    logic wr_ok;
    assign wr_ok = we && priv;

    always_ff @(posedge clk) begin
        if (rst)
            len_q <= '0;
        else if (wr_ok && sel_len)
            len_q <= len_in;
    end

    for (genvar g = 0; g < NPG; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                frame_q[g] <= '0;
                ok_q[g]    <= 1'b0;
            end else if (wr_ok && !sel_len && idx == PG_W'(g)) begin
                frame_q[g] <= frame_in;
                ok_q[g]    <= ok_in;
            end
        end
    end
endmodule

// File: rtl/pt_lookup.sv
module pt_lookup
    import pgx_pkg::*;
#(
    parameter int OFS_W = DEF_OFS_W,
    parameter int PG_W  = DEF_PG_W,
    parameter int FRM_W = DEF_FRM_W,
    localparam int NPG   = 1 << PG_W,
    localparam int LEN_W = PG_W + 1,
    localparam int LA_W  = PG_W + OFS_W,
    localparam int PA_W  = FRM_W + OFS_W
) (
    input  logic [LA_W-1:0]            laddr,
    input  logic [NPG-1:0][FRM_W-1:0]  frame_q,
    input  logic [NPG-1:0]             ok_q,
    input  logic [LEN_W-1:0]           len_q,
    output logic [PA_W-1:0]            paddr,
    output xl_cause_e                  cause
);
    logic [PG_W-1:0]  page;
    logic [OFS_W-1:0] ofs;

    assign page = laddr[LA_W-1:OFS_W];
    assign ofs  = laddr[OFS_W-1:0];

    always_comb begin
        if ({1'b0, page} >= len_q)
            cause = XL_BOUND;
        else if (!ok_q[page])
            cause = XL_INVALID;
        else
            cause = XL_OK;
        paddr = {frame_q[page], ofs};
    end
endmodule

// File: rtl/rsp_stage.sv
module rsp_stage
    import pgx_pkg::*;
#(
    parameter int PA_W = pgx_pkg::DEF_FRM_W + pgx_pkg::DEF_OFS_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fire,
    input  logic [PA_W-1:0] paddr_d,
    input  xl_cause_e       cause_d,
    output logic            vld_q,
    output logic [PA_W-1:0] paddr_q,
    output logic            fault_q
);
    always_ff @(posedge clk) begin
        if (rst || !fire) begin
            vld_q   <= 1'b0;
            paddr_q <= '0;
            fault_q <= 1'b0;
        end else begin
            vld_q   <= 1'b1;
            fault_q <= cause_is_fault(cause_d);
            paddr_q <= cause_is_fault(cause_d) ? '0 : paddr_d;
        end
    end
endmodule

// File: rtl/page_xlate_top.sv
module page_xlate_top
    import pgx_pkg::*;
#(
    parameter int OFS_W = DEF_OFS_W,
    parameter int PG_W  = DEF_PG_W,
    parameter int FRM_W = DEF_FRM_W,
    localparam int NPG   = 1 << PG_W,
    localparam int LEN_W = PG_W + 1,
    localparam int LA_W  = PG_W + OFS_W,
    localparam int PA_W  = FRM_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_priv,
    input  logic             cfg_sel_len,
    input  logic [PG_W-1:0]  cfg_idx,
    input  logic [FRM_W-1:0] cfg_frame,
    input  logic             cfg_entry_ok,
    input  logic [LEN_W-1:0] cfg_len,
    input  logic             req_valid,
    input  logic [LA_W-1:0]  req_laddr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic             rsp_fault
);
    logic [NPG-1:0][FRM_W-1:0] frame_q;
    logic [NPG-1:0]            ok_q;
    logic [LEN_W-1:0]          len_q;
    logic [PA_W-1:0]           lk_paddr;
    xl_cause_e                 lk_cause;

    pt_regfile #(.PG_W(PG_W), .FRM_W(FRM_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .priv     (cfg_priv),
        .sel_len  (cfg_sel_len),
        .idx      (cfg_idx),
        .frame_in (cfg_frame),
        .ok_in    (cfg_entry_ok),
        .len_in   (cfg_len),
        .frame_q  (frame_q),
        .ok_q     (ok_q),
        .len_q    (len_q)
    );

    pt_lookup #(.OFS_W(OFS_W), .PG_W(PG_W), .FRM_W(FRM_W)) u_look (
        .laddr   (req_laddr),
        .frame_q (frame_q),
        .ok_q    (ok_q),
        .len_q   (len_q),
        .paddr   (lk_paddr),
        .cause   (lk_cause)
    );

    rsp_stage #(.PA_W(PA_W)) u_rsp (
        .clk     (clk),
        .rst     (rst),
        .fire    (req_valid),
        .paddr_d (lk_paddr),
        .cause_d (lk_cause),
        .vld_q   (rsp_valid),
        .paddr_q (rsp_paddr),
        .fault_q (rsp_fault)
    );
endmodule

// File: rtl/pgx_chk.sv
module pgx_chk #(
    parameter int OFS_W = 3,
    parameter int PG_W  = 2,
    parameter int FRM_W = 4,
    localparam int LEN_W = PG_W + 1,
    localparam int LA_W  = PG_W + OFS_W,
    localparam int PA_W  = FRM_W + OFS_W
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input logic             cfg_priv,
    input logic             req_valid,
    input logic [LA_W-1:0]  req_laddr,
    input logic             rsp_valid,
    input logic [PA_W-1:0]  rsp_paddr,
    input logic             rsp_fault,
    input logic [LEN_W-1:0] len_q
);
    // R6
    pulse_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    // R6
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    // R1
    offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (rsp_fault || rsp_paddr[OFS_W-1:0] == $past(req_laddr[OFS_W-1:0])));
    // R3
    bound_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && {1'b0, req_laddr[LA_W-1:OFS_W]} >= len_q) |=> rsp_fault);
    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_fault |-> (rsp_valid && rsp_paddr == '0));
    // R5
    unpriv_len_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !cfg_priv) |=> $stable(len_q));
endmodule

bind page_xlate_top pgx_chk #(.OFS_W(OFS_W), .PG_W(PG_W), .FRM_W(FRM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_priv  (cfg_priv),
    .req_valid (req_valid),
    .req_laddr (req_laddr),
    .rsp_valid (rsp_valid),
    .rsp_paddr (rsp_paddr),
    .rsp_fault (rsp_fault),
    .len_q     (len_q)
);

// File: tb/sim_page_xlate_top.sv
module sim_page_xlate_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_we, cfg_priv, cfg_sel_len, cfg_entry_ok;
    logic [1:0] cfg_idx;
    logic [3:0] cfg_frame;
    logic [2:0] cfg_len;
    logic       req_valid;
    logic [4:0] req_laddr;
    logic       rsp_valid;
    logic [6:0] rsp_paddr;
    logic       rsp_fault;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // behavioural model state
    int  m_frame[4];
    bit  m_ok[4];
    int  m_len;

    always #(CLK_PERIOD/2) clk = ~clk;

    page_xlate_top u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_priv(cfg_priv),
        .cfg_sel_len(cfg_sel_len), .cfg_idx(cfg_idx), .cfg_frame(cfg_frame),
        .cfg_entry_ok(cfg_entry_ok), .cfg_len(cfg_len), .req_valid(req_valid),
        .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault)
    );

    task automatic compare(string tag, bit ev, int epa, bit ef);
        n_cmp++;
        if (rsp_valid !== ev || rsp_fault !== ef || int'(rsp_paddr) != epa) begin
            n_bad++;
            $display("FAIL %s: got v=%0b pa=%b f=%0b, expected v=%0b pa=%b f=%0b",
                     tag, rsp_valid, rsp_paddr, rsp_fault, ev, 7'(epa), ef);
        end
    endtask

    // One cycle: drive at negedge, predict, clock, compare at the next negedge.
    task automatic step(string tag, bit we, bit priv, bit sl, int idx, int frm,
                        bit ok, int len, bit rq, int la);
        bit ev; bit ef; int epa; int pg;
        cfg_we = we; cfg_priv = priv; cfg_sel_len = sl; cfg_idx = 2'(idx);
        cfg_frame = 4'(frm); cfg_entry_ok = ok; cfg_len = 3'(len);
        req_valid = rq; req_laddr = 5'(la);
        ev = rq; ef = 0; epa = 0;
        if (rq) begin
            pg = la / 8;
            if (pg >= m_len || !m_ok[pg]) ef = 1;
            else epa = m_frame[pg] * 8 + (la % 8);
        end
        if (we && priv) begin
            if (sl) m_len = len;
            else begin m_frame[idx] = frm; m_ok[idx] = ok; end
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag, ev, epa, ef);
    endtask

    task automatic wr_ent(string tag, int idx, int frm, bit ok);
        step(tag, 1, 1, 0, idx, frm, ok, 0, 0, 0);
    endtask

    task automatic wr_len(string tag, int len);
        step(tag, 1, 1, 1, 0, 0, 0, len, 0, 0);
    endtask

    task automatic xl(string tag, int la);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 1, la);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_frame[i] = 0; m_ok[i] = 0; end
        m_len = 0;
        rst = 1; cfg_we = 0; cfg_priv = 0; cfg_sel_len = 0; cfg_idx = 0;
        cfg_frame = 0; cfg_entry_ok = 0; cfg_len = 0; req_valid = 1; req_laddr = 0;
        repeat (3) @(negedge clk);
        compare("R7 reset idle", 0, 0, 0);
        rst = 0;
        // R7: empty table faults
        xl("R7 after reset", 5'b00_000);
        xl("R7 after reset", 5'b11_111);
        // R5: unprivileged writes dropped
        step("R5 unpriv len", 1, 0, 1, 0, 0, 0, 4, 0, 0);
        step("R5 unpriv ent", 1, 0, 0, 0, 9, 1, 0, 0, 0);
        xl("R5 still faults", 5'b00_011);
        // load table: 0->3, 1->6, 2->4, length 3
        wr_ent("R8 load", 0, 3, 1);
        wr_ent("R8 load", 1, 6, 1);
        wr_ent("R8 load", 2, 4, 1);
        wr_len("R8 load", 3);
        xl("R2 page1", 5'b01_000);
        xl("R2 page2", 5'b10_111);
        xl("R1 page0", 5'b00_101);
        for (int o = 0; o < 8; o++) xl("R1 offsets", 8 + o);
        // R3: boundary page == length
        xl("R3 page eq len", 5'b11_010);
        // R4: in range but invalid
        wr_len("R4 len4", 4);
        xl("R4 invalid entry", 5'b11_001);
        // R8: write and request in same cycle sees old, next sees new
        step("R8 same cycle", 1, 1, 0, 3, 15, 1, 0, 1, 5'b11_110);
        xl("R8 next cycle", 5'b11_110);
        // R4: invalidate an entry
        wr_ent("R4 clear", 1, 6, 0);
        xl("R4 cleared entry", 5'b01_100);
        // R3: shrink length
        wr_len("R3 len2", 2);
        xl("R3 page2 out", 5'b10_000);
        xl("R3 page0 in", 5'b00_111);
        // R6: idle cycles and pulse shape
        step("R6 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6 idle", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        xl("R6 single", 5'b00_001);
        step("R6 drop", 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R9: fault after valid translation
        xl("R9 ok", 5'b00_010);
        xl("R9 fault zero", 5'b11_111);
        // R5: unprivileged length change while loaded
        step("R5 unpriv len0", 1, 0, 1, 0, 0, 0, 0, 1, 5'b00_100);
        xl("R5 len kept", 5'b00_100);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule